// File: doc/BRIEF.md
# Delayed Transaction Discard Timer

This block watches the head of a bridge's queue of completed delayed transactions. When a completion reaches the head, the block starts counting bus clocks. If the original initiator retries the request before the count runs out, the timer stops and waits for the next entry. If the count runs out first, the block discards the completion, sets a sticky status flag and, when error reporting is on, asks the primary side to raise a system error.

Software picks one of two timeout ranges with one select bit. It clears the status flag by writing a one to it. The queue storage and the matching of retries to entries live outside the block: the block only sees a head-valid flag and a retry-match strobe. The queue is expected to pop its head in the cycle after a discard or a matched retry.

Top module: `dt_discard_timer`

## Requirements
- R1: After reset, `discard_o`, `status_o` and `serr_req_o` are all 0.
- R2: While `head_valid_i` is low and the timer is idle, no count runs and no discard happens. A strobe on `retry_match_i` in this state has no effect.
- R3: With `short_range_i` = 0, `discard_o` goes high exactly 2^LONG_BIT clocks after the clock edge that samples `head_valid_i` high in the idle state. With the defaults this is 32768 clocks, which lies inside the 2^15 to 2^16 window.
- R4: With `short_range_i` = 1, `discard_o` goes high exactly 2^SHORT_BIT clocks after that arming edge. With the defaults this is 1024 clocks, which lies inside the 2^10 to 2^11 window.
- R5: A `retry_match_i` strobe sampled while the count runs, before expiry, returns the timer to idle with no discard and no status change.
- R6: After a discard or a retry, the timer returns to idle for one clock. It then arms again if `head_valid_i` is high. An entry held at the head across a discard therefore expires again 2^b + 2 clocks after the first discard.
- R7: `discard_o` is high for exactly one clock per expiry.
- R8: An expiry sets `status_o` on the next clock edge. The bit then stays at 1 until it is cleared.
- R9: A one on `status_clr_i` clears `status_o` on the next edge. If a clear and an expiry fall in the same cycle, `status_o` stays at 1.
- R10: `serr_req_o` is high in the same cycle as `discard_o` when `err_en_i` = 1. It stays at 0 when `err_en_i` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low reset |
| head_valid_i | input | 1 | A completed delayed transaction is at the queue head |
| retry_match_i | input | 1 | The initiator's retry matched the head entry |
| short_range_i | input | 1 | 1 selects the short timeout range, 0 the long range |
| err_en_i | input | 1 | Enables the system-error request on a discard |
| status_clr_i | input | 1 | Write-one strobe that clears the status flag |
| discard_o | output | 1 | One-clock pulse: drop the head entry |
| status_o | output | 1 | Sticky flag: a discard has happened |
| serr_req_o | output | 1 | One-clock system-error request toward the primary side |

## Verification
The bench builds the block with LONG_BIT = 9 and SHORT_BIT = 5, so the long range is 512 clocks and the short range is 32. This keeps both ranges and back-to-back expiries within a short run. The exact expiry cycle is predicted from the arming edge and compared against the cycle in which the pulse appears. The smaller values also bring within reach the case of a status clear landing in the same cycle as an expiry, and the case of a retry arriving partway through a count.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dtt_state_e;

  // Counter bit whose setting marks expiry for the selected range.
  function automatic int unsigned dtt_limit_bit(input logic short_sel,
                                                input int unsigned long_bit,
                                                input int unsigned short_bit);
    return short_sel ? short_bit : long_bit;
  endfunction

endpackage

// File: rtl/dtt_timer.sv
module dtt_timer
  import dtt_pkg::*;
#(
  parameter int unsigned LONG_BIT  = 15,
  parameter int unsigned SHORT_BIT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic head_valid_i,
  input  logic retry_i,
  input  logic short_sel_i,
  output logic expire_o
);

  localparam int unsigned CNT_W = LONG_BIT + 1;
  localparam int unsigned IDX_W = (CNT_W > 1) ? $clog2(CNT_W) : 1;

  dtt_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] sel_idx;
  logic             hit_w;
  logic             expire_w;

  assign sel_idx  = IDX_W'(dtt_limit_bit(short_sel_i, LONG_BIT, SHORT_BIT));
  // The long-range bit always ends the count, so a range change mid-count stays bounded.
  assign hit_w    = cnt_q[sel_idx] | cnt_q[LONG_BIT];
  assign expire_w = (state_q == ST_RUN) && hit_w;
  assign expire_o = expire_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (head_valid_i) state_q <= ST_RUN;
        end
        default: begin
          if (expire_w || retry_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R5
  retry_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && retry_i && !expire_w) |=> !expire_o);

  // R7
  discard_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_w |=> !expire_w);

  // R3
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (cnt_q <= CNT_W'(1 << LONG_BIT)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !head_valid_i) |=> (state_q == ST_IDLE && cnt_q == '0));

endmodule

// File: rtl/dtt_status.sv
module dtt_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic err_en_i,
  output logic status_o,
  output logic err_o
);

  logic status_q;

  // A new expiry takes priority over a clear in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= 1'b0;
    else         status_q <= (status_q & ~clr_i) | expire_i;
  end

  assign status_o = status_q;
  assign err_o    = expire_i & err_en_i;

  // R8
  status_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> status_q);

  // R9
  status_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && clr_i && !expire_i) |=> !status_q);

  // R8
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !clr_i) |=> status_q);

endmodule

// File: rtl/dt_discard_timer.sv
module dt_discard_timer #(
  parameter int unsigned LONG_BIT  = 15,
  parameter int unsigned SHORT_BIT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic head_valid_i,
  input  logic retry_match_i,
  input  logic short_range_i,
  input  logic err_en_i,
  input  logic status_clr_i,
  output logic discard_o,
  output logic status_o,
  output logic serr_req_o
);

  logic expire_w;

  dtt_timer #(
    .LONG_BIT  (LONG_BIT),
    .SHORT_BIT (SHORT_BIT)
  ) i_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .head_valid_i (head_valid_i),
    .retry_i      (retry_match_i),
    .short_sel_i  (short_range_i),
    .expire_o     (expire_w)
  );

  dtt_status i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire_w),
    .clr_i    (status_clr_i),
    .err_en_i (err_en_i),
    .status_o (status_o),
    .err_o    (serr_req_o)
  );

  assign discard_o = expire_w;

  // R10
  err_with_discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_req_o |-> (discard_o && err_en_i));

  // R10
  err_follows_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (discard_o && err_en_i) |-> serr_req_o);

endmodule

// File: tb/test_dt_discard_timer.sv
module test_dt_discard_timer;

  localparam int LB = 9;
  localparam int SB = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hv = 1'b0, retry = 1'b0, shrt = 1'b0, en = 1'b0, clr = 1'b0;
  logic discard, status, serr;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int seen = 0;
  int exp_cyc[$];
  bit exp_err[$];
  bit prev_disc = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  dt_discard_timer #(.LONG_BIT(LB), .SHORT_BIT(SB)) i_dt_discard_timer (
    .clk_i(clk), .rst_ni(rst_n), .head_valid_i(hv), .retry_match_i(retry),
    .short_range_i(shrt), .err_en_i(en), .status_clr_i(clr),
    .discard_o(discard), .status_o(status), .serr_req_o(serr)
  );

  function automatic int span(bit s);
    return s ? (2 ** SB) : (2 ** LB);
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Monitor: sample 5 ns after the rising edge and compare against the scoreboard.
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      if (discard) begin
        seen++;
        chk(!prev_disc, "R7 single-cycle discard", 1, 0);
        if (exp_cyc.size() == 0) begin
          chk(1'b0, "R2 R5 unexpected discard", cyc, -1);
        end else begin
          int ec;
          bit ee;
          ec = exp_cyc.pop_front();
          ee = exp_err.pop_front();
          chk(cyc == ec, "R3 R4 R6 discard cycle", cyc, ec);
          chk(serr == ee, "R10 error request", int'(serr), int'(ee));
        end
      end else begin
        chk(!serr, "R10 error without discard", int'(serr), 0);
      end
      prev_disc = discard;
    end
  end

  // Driver: arm one entry and push the expected discard.
  task automatic arm(bit s, bit e, bit expect_disc, output int c);
    @(negedge clk);
    shrt = s; en = e; hv = 1'b1;
    c = cyc;
    if (expect_disc) begin
      exp_cyc.push_back(c + 1 + span(s));
      exp_err.push_back(e);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_status();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    int c, d1, s0;
    wait_cyc(3);
    chk(!discard && !status && !serr, "R1 reset outputs", {discard, status, serr}, 0);
    rst_n = 1'b1;
    wait_cyc(2);
    chk(!discard && !status && !serr, "R1 after reset release", {discard, status, serr}, 0);

    // R2: no head entry, retries ignored
    s0 = seen;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); retry = (i % 7 == 0);
    end
    retry = 1'b0;
    wait_cyc(600);
    chk(seen == s0, "R2 idle no discard", seen - s0, 0);
    chk(!status, "R2 idle status", int'(status), 0);

    // R3: long range, error enabled
    arm(1'b0, 1'b1, 1'b1, c);
    @(negedge clk); hv = 1'b0;
    while (cyc < c + span(1'b0) + 4) @(negedge clk);
    chk(exp_cyc.size() == 0, "R3 long discard seen", exp_cyc.size(), 0);
    chk(status, "R8 status set", int'(status), 1);
    wait_cyc(20);
    chk(status, "R8 status sticky", int'(status), 1);
    clear_status();
    @(negedge clk);
    chk(!status, "R9 status cleared", int'(status), 0);

    // R4: short range, error disabled
    arm(1'b1, 1'b0, 1'b1, c);
    @(negedge clk); hv = 1'b0;
    while (cyc < c + span(1'b1) + 4) @(negedge clk);
    chk(exp_cyc.size() == 0, "R4 short discard seen", exp_cyc.size(), 0);
    chk(status, "R8 status after short", int'(status), 1);
    clear_status();
    @(negedge clk);
    chk(!status, "R9 clear again", int'(status), 0);

    // R5: retry before expiry
    s0 = seen;
    arm(1'b1, 1'b1, 1'b0, c);
    @(negedge clk); hv = 1'b0;
    wait_cyc(10);
    retry = 1'b1;
    @(negedge clk); retry = 1'b0;
    wait_cyc(100);
    chk(seen == s0, "R5 retry cancels discard", seen - s0, 0);
    chk(!status, "R5 retry leaves status", int'(status), 0);

    // R6: entry held at head, re-arms after discard
    s0 = seen;
    arm(1'b1, 1'b1, 1'b1, c);
    d1 = c + 1 + span(1'b1);
    exp_cyc.push_back(d1 + 2 + span(1'b1));
    exp_err.push_back(1'b1);
    while (cyc != d1 + 2) @(negedge clk);
    hv = 1'b0;
    while (cyc < d1 + span(1'b1) + 6) @(negedge clk);
    chk(seen - s0 == 2, "R6 two back-to-back discards", seen - s0, 2);
    clear_status();
    @(negedge clk);
    chk(!status, "R9 clear before coincident case", int'(status), 0);

    // R9: clear in the same cycle as an expiry
    arm(1'b1, 1'b0, 1'b1, c);
    d1 = c + 1 + span(1'b1);
    @(negedge clk); hv = 1'b0;
    while (cyc != d1) @(negedge clk);
    clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk(status, "R9 expiry beats clear", int'(status), 1);
    wait_cyc(5);
    chk(exp_cyc.size() == 0, "R4 coincident discard seen", exp_cyc.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule